// File: doc/BRIEF.md
# Context-Tagged Virtual Write-Through Data Cache

This block is a direct-mapped data cache that is both indexed and tagged with virtual addresses. It sits between a processor load/store port and a simple request/response memory bus. Each of the 4096 sixteen-byte lines carries a tag that records the tag-ID bits of the virtual address and the 3-bit address-space context that filled it. The tag also holds copies of the page's writable and privileged bits, so that hits can be checked for protection without consulting the translation unit again.

Stores are always written through to memory. A store updates the cached word only when it hits, and a store miss never allocates a line. A load miss fetches the whole line as four 32-bit beats before it answers. A global enable turns the cache off: while it is low, every access goes to memory and nothing in the tag store is matched or changed. A separate maintenance port reads and writes raw tag words so that software can inspect lines or invalidate them one at a time.

Top module: `ctx_wt_cache`

## Requirements
- R1: Accesses are 32-bit words. The address splits as word select [3:2], line index [15:4] and tag ID [29:16], and bits [31:30] and [1:0] take no part in lookup. A hit needs the enable set, the line valid, the stored context equal to `cpu_ctx` and the stored tag ID equal to address [29:16].
- R2: When a load misses with the cache enabled, the block issues exactly four memory reads at the line's word addresses in ascending order (byte offsets 0, 4, 8, 12). It then returns the requested word and marks the line valid with `cpu_ctx`, `pte_wr` and `pte_priv`.
- R3: A load hit returns the cached word and issues no memory request.
- R4: Each store that does not fault issues exactly one memory write of `cpu_wdata` to the word address (address with bits [1:0] cleared). A store hit also updates the cached word. A store miss leaves the cache unchanged.
- R5: A store that hits a line with writable clear, or a user-mode access (`cpu_user`=1) that hits a line with privileged set, finishes with `cpu_fault`=1. Such an access issues no memory request and leaves the line unchanged.
- R6: While `cache_en` is 0, a load issues a single memory read and returns its data, and a store issues a single write. Neither one matches or modifies any line, and lines that were valid hit again once the enable returns.
- R7: A maintenance tag word has context in [24:22], writable in [21], privileged in [20], valid in [19] and tag ID in [15:2]. Bits [31:25], [18:16] and [1:0] always read back as 0, whatever value was written.
- R8: A maintenance write replaces the line's tag fields and valid bit, and later lookups use the new value. Clearing valid makes the next load of that line a miss.
- R9: Reset clears every valid bit, so no line hits until it has been filled or written.
- R10: `cpu_done` and `mnt_ack` are single-cycle pulses, one for each accepted request. `mem_req` stays asserted with a stable address, write flag and data until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cache_en | input | 1 | Global cache enable |
| cpu_req | input | 1 | Access request; held until `cpu_done` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_user | input | 1 | 1 = user mode, 0 = supervisor |
| cpu_addr | input | 32 | Virtual byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_ctx | input | 3 | Current address-space context |
| pte_wr | input | 1 | Page writable bit, recorded on fill |
| pte_priv | input | 1 | Page privileged bit, recorded on fill |
| cpu_done | output | 1 | Access complete pulse |
| cpu_fault | output | 1 | Protection fault, valid with `cpu_done` |
| cpu_rdata | output | 32 | Load data, valid with `cpu_done` |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write flag |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory beat accepted / read data valid |
| mem_rdata | input | 32 | Memory read data |
| mnt_req | input | 1 | Maintenance request; held until `mnt_ack` |
| mnt_we | input | 1 | 1 = write tag word |
| mnt_idx | input | 12 | Line index for maintenance |
| mnt_wdata | input | 32 | Tag word to write |
| mnt_ack | output | 1 | Maintenance complete pulse |
| mnt_rdata | output | 32 | Tag word as it was before the access |

## Verification
The bench uses the default parameters: 12 index bits, 14 tag-ID bits and 3 context bits. At that size the full tag-word layout is visible at the maintenance port, and line 4095 exercises the top of the index range. Random addresses are drawn from a few line indices that share several tag IDs and differ in bits [31:30]. This makes evictions, context mismatches, aliases that ignore the high bits, and stale lines left by stores made while the cache was disabled common rather than rare.

// File: rtl/cwt_pkg.sv
package cwt_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int CTX_W  = 3;
  localparam int IDX_W  = 12;
  localparam int OFF_W  = 4;
  localparam int WORDS  = 2 ** (OFF_W - 2);
  localparam int TID_W  = 30 - IDX_W - OFF_W;
  localparam int TID_LSB = OFF_W + IDX_W;

  typedef struct packed {
    logic [CTX_W-1:0] ctx;
    logic             wr;
    logic             pr;
    logic [TID_W-1:0] tid;
  } tag_t;

  typedef enum logic [2:0] {S_IDLE, S_FILL, S_WR, S_UNC, S_RESP} state_t;

  // Tag word: ctx [24:22], wr [21], pr [20], valid [19], tid [15:2], rest zero
  function automatic logic [31:0] tag_to_word(tag_t t, logic v);
    logic [31:0] w;
    w = '0;
    w[22 +: CTX_W] = t.ctx;
    w[21] = t.wr;
    w[20] = t.pr;
    w[19] = v;
    w[2 +: TID_W] = t.tid;
    return w;
  endfunction

  function automatic tag_t word_to_tag(logic [31:0] w);
    tag_t t;
    t.ctx = w[22 +: CTX_W];
    t.wr  = w[21];
    t.pr  = w[20];
    t.tid = w[2 +: TID_W];
    return t;
  endfunction
endpackage

// File: rtl/cwt_tag_store.sv
module cwt_tag_store
  import cwt_pkg::*;
#(
  parameter int IDX_W = cwt_pkg::IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output tag_t             rd_tag,
  output logic             rd_vld,
  input  logic [IDX_W-1:0] mnt_idx,
  output tag_t             mnt_tag,
  output logic             mnt_vld,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  tag_t             wr_tag,
  input  logic             wr_vld
);
  localparam int LINES = 2 ** IDX_W;

  logic [LINES-1:0] vld;
  tag_t             tags [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vld <= '0;
    else if (wr_en) vld[wr_idx] <= wr_vld;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tags[wr_idx] <= wr_tag;
  end

  assign rd_tag  = tags[rd_idx];
  assign rd_vld  = vld[rd_idx];
  assign mnt_tag = tags[mnt_idx];
  assign mnt_vld = vld[mnt_idx];

  // R8
  vld_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld[$past(wr_idx)] == $past(wr_vld));
endmodule

// File: rtl/cwt_data_store.sv
module cwt_data_store
  import cwt_pkg::*;
#(
  parameter int IDX_W = cwt_pkg::IDX_W
) (
  input  logic                     clk,
  input  logic [IDX_W-1:0]         rd_idx,
  input  logic [$clog2(WORDS)-1:0] rd_word,
  output logic [DATA_W-1:0]        rd_data,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [$clog2(WORDS)-1:0] wr_word,
  input  logic [DATA_W-1:0]        wr_data
);
  localparam int LINES  = 2 ** IDX_W;
  localparam int WSEL_W = $clog2(WORDS);

  logic [DATA_W-1:0] lane_rd [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_lane
    logic [DATA_W-1:0] arr [LINES];
    always_ff @(posedge clk) begin
      if (wr_en && wr_word == WSEL_W'(g)) arr[wr_idx] <= wr_data;
    end
    assign lane_rd[g] = arr[rd_idx];
  end

  assign rd_data = lane_rd[rd_word];
endmodule

// File: rtl/cwt_ctrl.sv
module cwt_ctrl
  import cwt_pkg::*;
#(
  parameter int IDX_W = cwt_pkg::IDX_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cache_en,
  input  logic                     cpu_req,
  input  logic                     cpu_we,
  input  logic                     cpu_user,
  input  logic [ADDR_W-1:2]        cpu_addr,
  input  logic [DATA_W-1:0]        cpu_wdata,
  input  logic [CTX_W-1:0]         cpu_ctx,
  input  logic                     pte_wr,
  input  logic                     pte_priv,
  output logic                     cpu_done,
  output logic                     cpu_fault,
  output logic [DATA_W-1:0]        cpu_rdata,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [DATA_W-1:0]        mem_wdata,
  input  logic                     mem_ack,
  input  logic [DATA_W-1:0]        mem_rdata,
  input  logic                     mnt_req,
  input  logic                     mnt_we,
  input  logic [IDX_W-1:0]         mnt_idx,
  input  logic [31:0]              mnt_wdata,
  output logic                     mnt_ack,
  output logic [31:0]              mnt_rdata,
  output logic [IDX_W-1:0]         tag_rd_idx,
  input  tag_t                     tag_rd,
  input  logic                     tag_rd_vld,
  input  tag_t                     mnt_tag,
  input  logic                     mnt_vld,
  output logic                     tag_we,
  output logic [IDX_W-1:0]         tag_widx,
  output tag_t                     tag_wtag,
  output logic                     tag_wvld,
  output logic [IDX_W-1:0]         dat_rd_idx,
  output logic [$clog2(WORDS)-1:0] dat_rd_word,
  input  logic [DATA_W-1:0]        dat_rd,
  output logic                     dat_we,
  output logic [$clog2(WORDS)-1:0] dat_wword,
  output logic [DATA_W-1:0]        dat_wdata
);
  localparam int WSEL_W = $clog2(WORDS);

  state_t              st, st_nx;
  logic [ADDR_W-1:2]   q_addr;
  logic [DATA_W-1:0]   q_wdata;
  logic [CTX_W-1:0]    q_ctx;
  logic                q_pw, q_pp;
  logic [WSEL_W-1:0]   beat;
  logic                hit_q, fault_q, mnt_ack_q;
  logic [DATA_W-1:0]   rdata_q;
  logic [31:0]         mnt_rdata_q;

  logic idle, accept, mnt_go, hit, viol, last_beat, fill_done;
  logic [IDX_W-1:0] q_idx, lk_idx;

  assign idle      = (st == S_IDLE);
  assign accept    = idle && cpu_req;
  assign mnt_go    = idle && !cpu_req && mnt_req && !mnt_ack_q;
  assign q_idx     = q_addr[OFF_W +: IDX_W];
  assign lk_idx    = idle ? cpu_addr[OFF_W +: IDX_W] : q_idx;
  assign last_beat = (beat == WSEL_W'(WORDS - 1));
  assign fill_done = (st == S_FILL) && mem_ack && last_beat;

  // Lookup on the live request while idle
  assign hit  = cache_en && tag_rd_vld && (tag_rd.ctx == cpu_ctx)
             && (tag_rd.tid == cpu_addr[TID_LSB +: TID_W]);
  assign viol = hit && ((cpu_we && !tag_rd.wr) || (cpu_user && tag_rd.pr));

  assign tag_rd_idx  = lk_idx;
  assign dat_rd_idx  = lk_idx;
  assign dat_rd_word = cpu_addr[2 +: WSEL_W];

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE: if (cpu_req) begin
        if (viol)          st_nx = S_RESP;
        else if (cpu_we)   st_nx = S_WR;
        else if (hit)      st_nx = S_RESP;
        else if (cache_en) st_nx = S_FILL;
        else               st_nx = S_UNC;
      end
      S_FILL:        if (fill_done) st_nx = S_RESP;
      S_WR, S_UNC:   if (mem_ack)   st_nx = S_RESP;
      default:       st_nx = S_IDLE;
    endcase
  end

  // Single tag write port shared by line fill and maintenance
  always_comb begin
    tag_we   = fill_done || (mnt_go && mnt_we);
    tag_widx = fill_done ? q_idx : mnt_idx;
    tag_wvld = fill_done || mnt_wdata[19];
    if (fill_done) begin
      tag_wtag.ctx = q_ctx;
      tag_wtag.wr  = q_pw;
      tag_wtag.pr  = q_pp;
      tag_wtag.tid = q_addr[TID_LSB +: TID_W];
    end else begin
      tag_wtag = word_to_tag(mnt_wdata);
    end
  end

  assign dat_we    = mem_ack && ((st == S_FILL) || ((st == S_WR) && hit_q));
  assign dat_wword = (st == S_FILL) ? beat : q_addr[2 +: WSEL_W];
  assign dat_wdata = (st == S_FILL) ? mem_rdata : q_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      beat      <= '0;
      hit_q     <= 1'b0;
      fault_q   <= 1'b0;
      mnt_ack_q <= 1'b0;
    end else begin
      st        <= st_nx;
      mnt_ack_q <= mnt_go;
      if (accept) begin
        beat    <= '0;
        hit_q   <= hit;
        fault_q <= viol;
      end else if ((st == S_FILL) && mem_ack) begin
        beat    <= beat + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      q_addr  <= cpu_addr;
      q_wdata <= cpu_wdata;
      q_ctx   <= cpu_ctx;
      q_pw    <= pte_wr;
      q_pp    <= pte_priv;
      rdata_q <= dat_rd;
    end else if (mem_ack && (((st == S_FILL) && (beat == q_addr[2 +: WSEL_W])) || (st == S_UNC))) begin
      rdata_q <= mem_rdata;
    end
    if (mnt_go) mnt_rdata_q <= tag_to_word(mnt_tag, mnt_vld);
  end

  assign cpu_done  = (st == S_RESP);
  assign cpu_fault = fault_q;
  assign cpu_rdata = rdata_q;
  assign mem_req   = (st == S_FILL) || (st == S_WR) || (st == S_UNC);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = (st == S_FILL) ? {q_addr[ADDR_W-1:OFF_W], beat, 2'b00}
                                    : {q_addr, 2'b00};
  assign mem_wdata = q_wdata;
  assign mnt_ack   = mnt_ack_q;
  assign mnt_rdata = mnt_rdata_q;

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);
  // R5
  fault_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done && cpu_fault |-> !$past(mem_req));
  // R6
  off_nofill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle && cpu_req && !cache_en |=> st != S_FILL);
endmodule

// File: rtl/ctx_wt_cache.sv
module ctx_wt_cache
  import cwt_pkg::*;
#(
  parameter int IDX_W = cwt_pkg::IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_en,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              cpu_user,
  input  logic [31:0]       cpu_addr,
  input  logic [31:0]       cpu_wdata,
  input  logic [2:0]        cpu_ctx,
  input  logic              pte_wr,
  input  logic              pte_priv,
  output logic              cpu_done,
  output logic              cpu_fault,
  output logic [31:0]       cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  input  logic              mnt_req,
  input  logic              mnt_we,
  input  logic [IDX_W-1:0]  mnt_idx,
  input  logic [31:0]       mnt_wdata,
  output logic              mnt_ack,
  output logic [31:0]       mnt_rdata
);
  localparam int WSEL_W = $clog2(WORDS);

  logic [IDX_W-1:0]  tag_rd_idx, tag_widx, dat_rd_idx;
  tag_t              tag_rd, mnt_tag, tag_wtag;
  logic              tag_rd_vld, mnt_vld, tag_we, tag_wvld, dat_we;
  logic [WSEL_W-1:0] dat_rd_word, dat_wword;
  logic [31:0]       dat_rd, dat_wdata;
  logic              unused_lsb;

  assign unused_lsb = ^cpu_addr[1:0];

  cwt_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk, .rst_n, .cache_en, .cpu_req, .cpu_we, .cpu_user,
    .cpu_addr(cpu_addr[31:2]), .cpu_wdata, .cpu_ctx, .pte_wr, .pte_priv,
    .cpu_done, .cpu_fault, .cpu_rdata,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata,
    .mnt_req, .mnt_we, .mnt_idx, .mnt_wdata, .mnt_ack, .mnt_rdata,
    .tag_rd_idx, .tag_rd, .tag_rd_vld, .mnt_tag, .mnt_vld,
    .tag_we, .tag_widx, .tag_wtag, .tag_wvld,
    .dat_rd_idx, .dat_rd_word, .dat_rd, .dat_we, .dat_wword, .dat_wdata
  );

  cwt_tag_store #(.IDX_W(IDX_W)) u_tags (
    .clk, .rst_n,
    .rd_idx(tag_rd_idx), .rd_tag(tag_rd), .rd_vld(tag_rd_vld),
    .mnt_idx, .mnt_tag, .mnt_vld,
    .wr_en(tag_we), .wr_idx(tag_widx), .wr_tag(tag_wtag), .wr_vld(tag_wvld)
  );

  cwt_data_store #(.IDX_W(IDX_W)) u_data (
    .clk,
    .rd_idx(dat_rd_idx), .rd_word(dat_rd_word), .rd_data(dat_rd),
    .wr_en(dat_we), .wr_idx(tag_rd_idx), .wr_word(dat_wword), .wr_data(dat_wdata)
  );

  // R7
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mnt_ack |-> (mnt_rdata[31:25] == '0) && (mnt_rdata[18:16] == '0) && (mnt_rdata[1:0] == '0));
endmodule

// File: tb/test_ctx_wt_cache.sv
module test_ctx_wt_cache;
  localparam int CLK_PERIOD = 10;
  localparam int NLINES = 4096;

  logic clk = 1'b0;
  logic rst_n;
  logic cache_en, cpu_req, cpu_we, cpu_user, pte_wr, pte_priv;
  logic [31:0] cpu_addr, cpu_wdata;
  logic [2:0]  cpu_ctx;
  logic cpu_done, cpu_fault;
  logic [31:0] cpu_rdata;
  logic mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic mnt_req, mnt_we, mnt_ack;
  logic [11:0] mnt_idx;
  logic [31:0] mnt_wdata, mnt_rdata;

  ctx_wt_cache i_ctx_wt_cache (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int rd_cnt = 0, wr_cnt = 0, dly = 0;
  logic [31:0] rd_log [0:7];
  logic [31:0] last_wa, last_wd;
  logic [31:0] mem_w [logic [31:0]];

  // Reference state, one entry per line
  bit          r_vld [NLINES];
  bit          r_known [NLINES];
  logic [2:0]  r_ctx [NLINES];
  bit          r_w [NLINES], r_p [NLINES];
  logic [13:0] r_tid [NLINES];
  logic [31:0] r_dat [NLINES][4];

  function automatic logic [31:0] mem_val(logic [31:0] a);
    if (mem_w.exists(a)) return mem_w[a];
    return (a * 32'h9E3779B1) ^ 32'h0BADF00D;
  endfunction

  function automatic logic [31:0] exp_word(int i);
    return {7'b0, r_ctx[i], r_w[i], r_p[i], r_vld[i], 3'b0, r_tid[i], 2'b00};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Memory responder: 0-2 idle cycles, then a one-cycle ack
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (rst_n && mem_req) begin
        if (dly == 0) begin
          mem_ack = 1'b1;
          mem_rdata = mem_val(mem_addr);
          if (mem_we) begin
            wr_cnt++;
            last_wa = mem_addr;
            last_wd = mem_wdata;
          end else begin
            if (rd_cnt < 8) rd_log[rd_cnt] = mem_addr;
            rd_cnt++;
          end
          dly = $urandom % 3;
        end else dly--;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    summary();
  end

  task automatic do_cpu(bit we, bit user, logic [31:0] addr, logic [31:0] wd,
                        logic [2:0] ctx, bit pw, bit pp);
    int idx = int'(addr[15:4]);
    int wi  = int'(addr[3:2]);
    logic [31:0] wa = {addr[31:2], 2'b00};
    bit hit = cache_en && r_vld[idx] && r_ctx[idx] == ctx && r_tid[idx] == addr[29:16];
    bit flt = hit && ((we && !r_w[idx]) || (user && r_p[idx]));
    logic [31:0] exp_d = hit ? r_dat[idx][wi] : mem_val(wa);
    int exp_rd = (flt || we || hit) ? 0 : (cache_en ? 4 : 1);
    int exp_wr = (!flt && we) ? 1 : 0;
    rd_cnt = 0; wr_cnt = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_user = user; cpu_addr = addr;
    cpu_wdata = wd; cpu_ctx = ctx; pte_wr = pw; pte_priv = pp;
    do @(negedge clk); while (!cpu_done);
    cpu_req = 1'b0;
    check("R5", "fault flag", {31'b0, cpu_fault}, {31'b0, flt});
    if (!flt && !we) check(hit ? "R3" : (cache_en ? "R2" : "R6"), "load data", cpu_rdata, exp_d);
    check(exp_rd == 4 ? "R2" : (hit ? "R3" : "R6"), "memory reads", rd_cnt, exp_rd);
    check(flt ? "R5" : "R4", "memory writes", wr_cnt, exp_wr);
    if (exp_wr == 1) begin
      check("R4", "write address", last_wa, wa);
      check("R4", "write data", last_wd, wd);
    end
    if (exp_rd == 4)
      for (int b = 0; b < 4; b++)
        check("R2", "fill beat address", rd_log[b], {addr[31:4], 2'(b), 2'b00});
    @(negedge clk);
    check("R10", "done pulse width", {31'b0, cpu_done}, 32'd0);
    if (!flt) begin
      if (we) begin
        mem_w[wa] = wd;
        if (hit) r_dat[idx][wi] = wd;
      end else if (!hit && cache_en) begin
        for (int b = 0; b < 4; b++) r_dat[idx][b] = mem_val({addr[31:4], 2'(b), 2'b00});
        r_vld[idx] = 1; r_known[idx] = 1; r_ctx[idx] = ctx;
        r_w[idx] = pw; r_p[idx] = pp; r_tid[idx] = addr[29:16];
      end
    end
  endtask

  task automatic do_mnt(bit we, int idx, logic [31:0] wd, string req);
    logic [31:0] exp = exp_word(idx);
    @(negedge clk);
    mnt_req = 1'b1; mnt_we = we; mnt_idx = 12'(idx); mnt_wdata = wd;
    do @(negedge clk); while (!mnt_ack);
    mnt_req = 1'b0;
    if (r_known[idx]) check(req, "tag word", mnt_rdata, exp);
    else check(req, "valid and reserved bits", mnt_rdata & 32'hFE0F_0003, {12'b0, r_vld[idx], 19'b0});
    @(negedge clk);
    check("R10", "mnt ack pulse width", {31'b0, mnt_ack}, 32'd0);
    if (we) begin
      r_known[idx] = 1; r_vld[idx] = wd[19]; r_ctx[idx] = wd[24:22];
      r_w[idx] = wd[21]; r_p[idx] = wd[20]; r_tid[idx] = wd[15:2];
    end
  endtask

  initial begin
    int idxs[4] = '{3, 7, 100, 4095};
    logic [13:0] tids[3] = '{14'h0000, 14'h0155, 14'h3FFF};
    void'($urandom(32'd2024));
    rst_n = 1'b0; cache_en = 1'b1; cpu_req = 0; cpu_we = 0; cpu_user = 0;
    cpu_addr = '0; cpu_wdata = '0; cpu_ctx = '0; pte_wr = 0; pte_priv = 0;
    mnt_req = 0; mnt_we = 0; mnt_idx = '0; mnt_wdata = '0;
    repeat (3) @(negedge clk);
    check("R9", "done in reset", {31'b0, cpu_done}, 32'd0);
    check("R10", "mem_req in reset", {31'b0, mem_req}, 32'd0);
    rst_n = 1'b1;
    // R9: lines start invalid
    do_mnt(0, 5, '0, "R9");
    do_mnt(0, 4095, '0, "R9");
    // R2 fill, R3 hits
    do_cpu(0, 0, 32'h1234_0058, '0, 3'd5, 1, 0);
    do_cpu(0, 0, 32'h1234_0058, '0, 3'd5, 1, 0);
    do_cpu(0, 0, 32'h1234_0050, '0, 3'd5, 1, 0);
    // R7 tag word of the filled line
    do_mnt(0, 5, '0, "R7");
    // R1: other context misses; high bits ignored
    do_cpu(0, 0, 32'h1234_005C, '0, 3'd4, 1, 0);
    do_cpu(0, 0, 32'hD234_005C, '0, 3'd4, 1, 0);
    // R4 store hit then read, store miss does not allocate
    do_cpu(1, 0, 32'h1234_0054, 32'hCAFE_0001, 3'd4, 1, 0);
    do_cpu(0, 0, 32'h1234_0054, '0, 3'd4, 1, 0);
    do_cpu(1, 0, 32'h0777_0204, 32'hBEEF_0002, 3'd1, 1, 0);
    do_cpu(0, 0, 32'h0777_0204, '0, 3'd1, 1, 0);
    // R5 protection: read-only line store, privileged line user access
    do_cpu(0, 0, 32'h0010_0300, '0, 3'd2, 0, 1);
    do_cpu(1, 0, 32'h0010_0304, 32'h1111_1111, 3'd2, 0, 1);
    do_cpu(0, 1, 32'h0010_0308, '0, 3'd2, 0, 1);
    do_cpu(0, 0, 32'h0010_0308, '0, 3'd2, 0, 1);
    // R6 disabled: uncached, then enabled again hits
    cache_en = 1'b0;
    do_cpu(0, 0, 32'h0010_0308, '0, 3'd2, 0, 1);
    do_cpu(1, 1, 32'h0010_0304, 32'h2222_2222, 3'd2, 0, 1);
    cache_en = 1'b1;
    do_cpu(0, 0, 32'h0010_0304, '0, 3'd2, 0, 1);
    // R7 reserved bits dropped, R8 invalidate
    do_mnt(1, 4095, 32'hFFFF_FFFF, "R7");
    do_mnt(0, 4095, '0, "R7");
    do_mnt(1, 5, 32'h0000_0000, "R8");
    do_cpu(0, 0, 32'h1234_0058, '0, 3'd5, 1, 0);
    // Random mix
    for (int n = 0; n < 400; n++) begin
      int i = idxs[$urandom % 4];
      logic [31:0] a = {2'($urandom), tids[$urandom % 3], 12'(i), 2'($urandom), 2'b00};
      cache_en = ($urandom % 10) != 0;
      if ($urandom % 12 == 0)
        do_mnt(($urandom % 3) == 0, i, $urandom, "R8");
      else
        do_cpu(($urandom % 10) < 3, $urandom % 2, a, $urandom, 3'($urandom % 2),
               ($urandom % 4) != 0, ($urandom % 4) == 0);
    end
    cache_en = 1'b1;
    summary();
  end
endmodule